// File: doc/BRIEF.md
# ADC Calibration Sequencer

This block orders the calibration work of a successive-approximation converter and times the BUSY flag that the rest of the chip watches. A calibration is requested either by an active-low pulse on the calibration pin or by a one-cycle software strobe. A 2-bit selector picks one of four kinds of calibration. For as long as the run lasts, the block holds BUSY high for a fixed number of master clocks that depends on the kind. It fires a one-cycle strobe as each trim phase begins: converter array trim, gain trim and offset trim. When the run ends it raises a one-cycle done pulse. The analog trimming itself lies outside the block; each phase is only a timed window.

Taking the pin low acts as an internal reset. It aborts any run in progress and blocks software strobes, and the rising edge that follows starts a new run. At power-on the block samples the pin once. If the pin is already high, no automatic run happens. If it is low, a capacitor is assumed to be charging, and the first rising edge starts a full calibration whatever the selector says.

The controller has seven named states. BOOT moves to CHECK unconditionally. CHECK goes to IDLE if the pin is high, otherwise to ARMED. ARMED goes to DAC_TRIM on a pin rise. IDLE goes to the first phase of the selected kind on a pin rise or on an accepted software strobe. DAC_TRIM goes to GAIN_TRIM when its window expires. GAIN_TRIM goes to OFFSET_TRIM when its window expires, or to IDLE for the gain-only kind. OFFSET_TRIM goes to IDLE when its window expires. Every trim state returns to IDLE at once when the pin is seen low.

Top module: `adc_cal_sequencer`

## Requirements
- R1: BUSY stays high for exactly FULL_CYCLES clocks for selector 2'b00 (full), 2*STEP_CYCLES for 2'b01 (gain then offset), and STEP_CYCLES for 2'b10 (offset only) and 2'b11 (gain only). The defaults are 125013 and 13880.
- R2: Each trim strobe is high for one cycle, in the first cycle of its phase. Counting from the first BUSY cycle as 0, the strobes fall as follows. Full: array strobe at 0, gain strobe at FULL_CYCLES-2*STEP_CYCLES, offset strobe at FULL_CYCLES-STEP_CYCLES. Gain then offset: gain strobe at 0, offset strobe at STEP_CYCLES. Offset only: offset strobe at 0. Gain only: gain strobe at 0. No other strobe fires.
- R3: A software strobe sampled while idle and while the pin is high raises BUSY one clock edge later.
- R4: A rising edge on the calibration pin while idle raises BUSY no more than two clock periods after the edge (two flip-flops on the path). The selector is sampled on the edge that raises BUSY.
- R5: When the pin is seen low during a run, BUSY falls on the second clock edge after the pin falls, with no done pulse. While the pin is low, software strobes are ignored.
- R6: If the pin is low on the first clock edge after reset, BUSY stays low and software strobes are ignored until the pin rises. That rise then starts a full calibration, whatever the selector says.
- R7: If the pin is high on the first clock edge after reset, no calibration starts by itself, and later pin pulses follow the selector.
- R8: A software strobe that arrives while BUSY is high changes neither the length nor the strobes of the run in progress.
- R9: On a completed run, done is high for exactly one cycle, the first cycle after the last BUSY cycle.
- R10: If the abort and the completion fall on the same clock edge, the abort wins and no done pulse is given.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Active-low power-on reset |
| cal_pin_ni | input | 1 | Calibration pin: low is internal reset, a rising edge starts a run |
| sw_cal_go_i | input | 1 | One-cycle software start strobe |
| cal_sel_i | input | 2 | Calibration kind: 00 full, 01 gain then offset, 10 offset, 11 gain |
| busy_o | output | 1 | High while a calibration runs |
| dac_trim_o | output | 1 | Strobe at the start of the array trim phase |
| gain_trim_o | output | 1 | Strobe at the start of the gain trim phase |
| offset_trim_o | output | 1 | Strobe at the start of the offset trim phase |
| done_o | output | 1 | One-cycle pulse when a run completes |

## Verification
Two events can fall on the same edge: the abort caused by the pin going low, and the natural end of the last phase. The bench provokes this by driving the pin low one sample before the final BUSY cycle, so that the synchronised low is seen on exactly the completing edge. The check passes if BUSY keeps its full length and no done pulse appears. A second run drops the pin one cycle later; there the completion lands first, so a done pulse is expected. The bench also delivers a software strobe on the last BUSY cycle, where it must be ignored rather than start a new run.

// File: rtl/cal_seq_pkg.sv
package cal_seq_pkg;

    typedef enum logic [2:0] {
        ST_BOOT,
        ST_CHECK,
        ST_ARMED,
        ST_IDLE,
        ST_DAC_TRIM,
        ST_GAIN_TRIM,
        ST_OFFSET_TRIM
    } cal_state_e;

    typedef enum logic [1:0] {
        KIND_FULL      = 2'b00,
        KIND_GAIN_OFFS = 2'b01,
        KIND_OFFS      = 2'b10,
        KIND_GAIN      = 2'b11
    } cal_kind_e;

    function automatic logic state_is_busy(cal_state_e s);
        return (s == ST_DAC_TRIM) || (s == ST_GAIN_TRIM) || (s == ST_OFFSET_TRIM);
    endfunction

    function automatic cal_state_e first_phase(cal_kind_e k);
        unique case (k)
            KIND_FULL:      return ST_DAC_TRIM;
            KIND_GAIN_OFFS: return ST_GAIN_TRIM;
            KIND_OFFS:      return ST_OFFSET_TRIM;
            KIND_GAIN:      return ST_GAIN_TRIM;
            default:        return ST_IDLE;
        endcase
    endfunction

endpackage

// File: rtl/cal_pin_sync.sv
module cal_pin_sync #(
    parameter logic IDLE_LEVEL = 1'b1
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic pin_i,
    output logic lvl_o,
    output logic rise_o
);

    logic stage1_q;
    logic stage2_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            stage1_q <= IDLE_LEVEL;
            stage2_q <= IDLE_LEVEL;
        end else begin
            stage1_q <= pin_i;
            stage2_q <= stage1_q;
        end
    end

    assign lvl_o  = stage1_q;
    assign rise_o = stage1_q & ~stage2_q;

endmodule

// File: rtl/cal_phase_timer.sv
module cal_phase_timer #(
    parameter int CW = 17
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          load_i,
    input  logic [CW-1:0] len_i,
    output logic          expire_o
);

    logic [CW-1:0] remain_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            remain_q <= '0;
        end else if (load_i) begin
            remain_q <= len_i - CW'(1);
        end else if (remain_q != '0) begin
            remain_q <= remain_q - CW'(1);
        end
    end

    assign expire_o = (remain_q == '0);

endmodule

// File: rtl/cal_seq_ctrl.sv
module cal_seq_ctrl
    import cal_seq_pkg::*;
#(
    parameter int FULL_CYCLES = 125013,
    parameter int STEP_CYCLES = 13880,
    parameter int CW          = $clog2(FULL_CYCLES + 1)
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          cal_lvl_i,
    input  logic          cal_rise_i,
    input  logic          sw_go_i,
    input  logic [1:0]    sel_i,
    input  logic          tmr_expire_i,
    output logic          tmr_load_o,
    output logic [CW-1:0] tmr_len_o,
    output logic          busy_o,
    output logic          dac_stb_o,
    output logic          gain_stb_o,
    output logic          offs_stb_o,
    output logic          done_o,
    output logic          idle_o
);

    localparam int DAC_CYCLES = FULL_CYCLES - 2 * STEP_CYCLES;

    cal_state_e st_q, st_nxt;
    cal_kind_e  kind_q, kind_nxt;

    // next-state decision
    always_comb begin
        st_nxt   = st_q;
        kind_nxt = kind_q;
        unique case (st_q)
            ST_BOOT:  st_nxt = ST_CHECK;
            ST_CHECK: st_nxt = cal_lvl_i ? ST_IDLE : ST_ARMED;
            ST_ARMED: begin
                if (cal_rise_i) begin
                    st_nxt   = ST_DAC_TRIM;
                    kind_nxt = KIND_FULL;
                end
            end
            ST_IDLE: begin
                if (cal_rise_i || (cal_lvl_i && sw_go_i)) begin
                    kind_nxt = cal_kind_e'(sel_i);
                    st_nxt   = first_phase(cal_kind_e'(sel_i));
                end
            end
            ST_DAC_TRIM: begin
                if (!cal_lvl_i)        st_nxt = ST_IDLE;
                else if (tmr_expire_i) st_nxt = ST_GAIN_TRIM;
            end
            ST_GAIN_TRIM: begin
                if (!cal_lvl_i)        st_nxt = ST_IDLE;
                else if (tmr_expire_i) st_nxt = (kind_q == KIND_GAIN) ? ST_IDLE : ST_OFFSET_TRIM;
            end
            ST_OFFSET_TRIM: begin
                if (!cal_lvl_i)        st_nxt = ST_IDLE;
                else if (tmr_expire_i) st_nxt = ST_IDLE;
            end
            default: st_nxt = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q   <= ST_BOOT;
            kind_q <= KIND_FULL;
        end else begin
            st_q   <= st_nxt;
            kind_q <= kind_nxt;
        end
    end

    // registered event outputs
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            dac_stb_o  <= 1'b0;
            gain_stb_o <= 1'b0;
            offs_stb_o <= 1'b0;
            done_o     <= 1'b0;
        end else begin
            dac_stb_o  <= (st_nxt == ST_DAC_TRIM)    && (st_q != ST_DAC_TRIM);
            gain_stb_o <= (st_nxt == ST_GAIN_TRIM)   && (st_q != ST_GAIN_TRIM);
            offs_stb_o <= (st_nxt == ST_OFFSET_TRIM) && (st_q != ST_OFFSET_TRIM);
            done_o     <= state_is_busy(st_q) && (st_nxt == ST_IDLE) && cal_lvl_i;
        end
    end

    assign tmr_load_o = (st_nxt != st_q) && state_is_busy(st_nxt);
    assign tmr_len_o  = (st_nxt == ST_DAC_TRIM) ? CW'(DAC_CYCLES) : CW'(STEP_CYCLES);
    assign busy_o     = state_is_busy(st_q);
    assign idle_o     = (st_q == ST_IDLE);

endmodule

// File: rtl/adc_cal_sequencer.sv
module adc_cal_sequencer #(
    parameter int FULL_CYCLES = 125013,
    parameter int STEP_CYCLES = 13880
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       cal_pin_ni,
    input  logic       sw_cal_go_i,
    input  logic [1:0] cal_sel_i,
    output logic       busy_o,
    output logic       dac_trim_o,
    output logic       gain_trim_o,
    output logic       offset_trim_o,
    output logic       done_o
);

    localparam int CW = $clog2(FULL_CYCLES + 1);

    logic          cal_lvl;
    logic          cal_rise;
    logic          tmr_load;
    logic [CW-1:0] tmr_len;
    logic          tmr_expire;
    logic          fsm_idle;

    cal_pin_sync #(.IDLE_LEVEL(1'b1)) u_sync (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .pin_i  (cal_pin_ni),
        .lvl_o  (cal_lvl),
        .rise_o (cal_rise)
    );

    cal_phase_timer #(.CW(CW)) u_timer (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .load_i   (tmr_load),
        .len_i    (tmr_len),
        .expire_o (tmr_expire)
    );

    cal_seq_ctrl #(
        .FULL_CYCLES (FULL_CYCLES),
        .STEP_CYCLES (STEP_CYCLES),
        .CW          (CW)
    ) u_ctrl (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .cal_lvl_i    (cal_lvl),
        .cal_rise_i   (cal_rise),
        .sw_go_i      (sw_cal_go_i),
        .sel_i        (cal_sel_i),
        .tmr_expire_i (tmr_expire),
        .tmr_load_o   (tmr_load),
        .tmr_len_o    (tmr_len),
        .busy_o       (busy_o),
        .dac_stb_o    (dac_trim_o),
        .gain_stb_o   (gain_trim_o),
        .offs_stb_o   (offset_trim_o),
        .done_o       (done_o),
        .idle_o       (fsm_idle)
    );

endmodule

// File: rtl/cal_seq_checker.sv
module cal_seq_checker (
    input logic clk_i,
    input logic rst_ni,
    input logic busy_i,
    input logic dac_i,
    input logic gain_i,
    input logic offs_i,
    input logic done_i,
    input logic sw_go_i,
    input logic cal_lvl_i,
    input logic idle_i
);

    // R2: at most one event output per cycle
    assert_one_event_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0({dac_i, gain_i, offs_i, done_i}));

    // R2: array trim can only open a run
    assert_dac_leads_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        dac_i |-> !$past(busy_i));

    // R2: every run opens with a phase strobe
    assert_run_opens_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(busy_i) |-> (dac_i || gain_i || offs_i));

    // R9: done only on the falling edge of BUSY
    assert_done_on_fall_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_i |-> ($past(busy_i) && !busy_i));

    // R3: accepted software start raises BUSY next edge
    assert_sw_start_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (idle_i && cal_lvl_i && sw_go_i) |=> busy_i);

    // R5 / R10: pin low aborts without done
    assert_abort_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (busy_i && !cal_lvl_i) |=> (!busy_i && !done_i));

endmodule

bind adc_cal_sequencer cal_seq_checker u_cal_seq_checker (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .busy_i    (busy_o),
    .dac_i     (dac_trim_o),
    .gain_i    (gain_trim_o),
    .offs_i    (offset_trim_o),
    .done_i    (done_o),
    .sw_go_i   (sw_cal_go_i),
    .cal_lvl_i (cal_lvl),
    .idle_i    (fsm_idle)
);

// File: tb/adc_cal_sequencer_test.sv
module adc_cal_sequencer_test;

    localparam int CLK_PERIOD = 10;
    localparam int FULL = 50;
    localparam int STEP = 12;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cal_n = 1'b1;
    logic       sw_go = 1'b0;
    logic [1:0] sel = 2'b00;
    logic       busy, dac, gain, offs, done;

    int n_checks = 0;
    int n_fail   = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    adc_cal_sequencer #(.FULL_CYCLES(FULL), .STEP_CYCLES(STEP)) uut (
        .clk_i         (clk),
        .rst_ni        (rst_n),
        .cal_pin_ni    (cal_n),
        .sw_cal_go_i   (sw_go),
        .cal_sel_i     (sel),
        .busy_o        (busy),
        .dac_trim_o    (dac),
        .gain_trim_o   (gain),
        .offset_trim_o (offs),
        .done_o        (done)
    );

    function automatic int exp_len(logic [1:0] k);
        return (k == 2'b00) ? FULL : (k == 2'b01) ? 2 * STEP : STEP;
    endfunction
    function automatic int exp_dac_at(logic [1:0] k);
        return (k == 2'b00) ? 0 : -1;
    endfunction
    function automatic int exp_gain_at(logic [1:0] k);
        return (k == 2'b00) ? FULL - 2 * STEP : (k == 2'b10) ? -1 : 0;
    endfunction
    function automatic int exp_offs_at(logic [1:0] k);
        return (k == 2'b00) ? FULL - STEP : (k == 2'b01) ? STEP : (k == 2'b10) ? 0 : -1;
    endfunction

    task automatic check(bit ok, string req, int act, int expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    endtask

    task automatic do_reset(logic pin_level);
        rst_n = 1'b0;
        cal_n = pin_level;
        sw_go = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(busy == 1'b0 && done == 1'b0, "R6 reset state", int'(busy), 0);
    endtask

    // trigger a run, follow it to its end and compare with the computed expectation
    task automatic run_cal(bit use_pin, logic [1:0] drv_sel, logic [1:0] exp_sel,
                           int inject_at, int abort_at, string len_req);
        int lat, idx, normal, elen, d_at, g_at, o_at, d_n, g_n, o_n;
        bit aborted, done_now, done_next;
        int e_d, e_g, e_o;
        sel = drv_sel;
        if (use_pin) begin
            cal_n = 1'b0;
            repeat (2) @(negedge clk);
            cal_n = 1'b1;
        end else begin
            sw_go = 1'b1;
        end
        lat = 0;
        do begin
            @(negedge clk);
            sw_go = 1'b0;
            lat++;
        end while (!busy && lat < 10);
        if (use_pin) check(lat == 2, "R4 pin start latency", lat, 2);
        else         check(lat == 1, "R3 software start latency", lat, 1);

        idx = 0; d_at = -1; g_at = -1; o_at = -1; d_n = 0; g_n = 0; o_n = 0;
        while (busy && idx < 1000) begin
            if (dac)  begin if (d_at < 0) d_at = idx; d_n++; end
            if (gain) begin if (g_at < 0) g_at = idx; g_n++; end
            if (offs) begin if (o_at < 0) o_at = idx; o_n++; end
            check(done == 1'b0, "R9 no done while busy", int'(done), 0);
            sw_go = 1'b0;
            sel = drv_sel;
            if (idx == inject_at) begin
                sw_go = 1'b1;
                sel = ~drv_sel;
            end
            if (idx == abort_at) cal_n = 1'b0;
            @(negedge clk);
            idx++;
        end
        sw_go = 1'b0;
        sel = drv_sel;
        done_now = done;
        @(negedge clk);
        done_next = done;

        normal  = exp_len(exp_sel);
        aborted = (abort_at >= 0) && (abort_at + 2 <= normal);
        elen    = aborted ? abort_at + 2 : normal;
        e_d = exp_dac_at(exp_sel);  if (e_d >= elen) e_d = -1;
        e_g = exp_gain_at(exp_sel); if (e_g >= elen) e_g = -1;
        e_o = exp_offs_at(exp_sel); if (e_o >= elen) e_o = -1;

        check(idx == elen, aborted ? "R5 aborted busy length" : len_req, idx, elen);
        check(d_at == e_d && d_n == (e_d >= 0 ? 1 : 0), "R2 array strobe position", d_at, e_d);
        check(g_at == e_g && g_n == (e_g >= 0 ? 1 : 0), "R2 gain strobe position", g_at, e_g);
        check(o_at == e_o && o_n == (e_o >= 0 ? 1 : 0), "R2 offset strobe position", o_at, e_o);
        check(done_now == !aborted, aborted ? "R10 no done on abort" : "R9 done after last busy",
              int'(done_now), int'(!aborted));
        check(done_next == 1'b0, "R9 done lasts one cycle", int'(done_next), 0);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_fail++;
        $display("FAIL watchdog: actual 1 expected 0");
        finish_run();
    end

    initial begin
        void'($urandom(32'd914273));

        // R6: pin low at power-on, auto full run on first rise
        do_reset(1'b0);
        repeat (4) @(negedge clk);
        check(busy == 1'b0, "R6 waits for pin rise", int'(busy), 0);
        sw_go = 1'b1;
        @(negedge clk);
        sw_go = 1'b0;
        @(negedge clk);
        check(busy == 1'b0, "R6 software ignored before rise", int'(busy), 0);
        run_cal(1'b1, 2'b11, 2'b00, -1, -1, "R6 auto run is full");

        // R1/R2/R3/R4/R8 random mix
        for (int i = 0; i < 16; i++) begin
            logic [1:0] k;
            bit pin;
            int inj;
            k   = 2'($urandom % 4);
            pin = 1'($urandom % 2);
            inj = ($urandom % 3 == 0) ? int'($urandom % exp_len(k)) : -1;
            repeat ($urandom % 4) @(negedge clk);
            run_cal(pin, k, k, inj, -1, (inj >= 0) ? "R8 busy length with request" : "R1 busy length");
        end

        // R8: requests at first and last busy cycle ignored
        run_cal(1'b0, 2'b10, 2'b10, 0, -1, "R8 request on first busy cycle");
        run_cal(1'b0, 2'b01, 2'b01, 2 * STEP - 1, -1, "R8 request on last busy cycle");

        // R5: abort mid-run, software ignored while pin low
        run_cal(1'b0, 2'b00, 2'b00, -1, 7, "R5");
        sw_go = 1'b1;
        @(negedge clk);
        sw_go = 1'b0;
        repeat (2) @(negedge clk);
        check(busy == 1'b0, "R5 software ignored while pin low", int'(busy), 0);
        run_cal(1'b1, 2'b01, 2'b01, -1, -1, "R1 busy length after abort");

        // R10: abort landing on the completion edge, then one cycle later
        run_cal(1'b0, 2'b11, 2'b11, -1, STEP - 2, "R10");
        run_cal(1'b1, 2'b10, 2'b10, -1, STEP - 1, "R10 late abort completes");
        run_cal(1'b1, 2'b00, 2'b00, -1, -1, "R1 full after late abort");

        // R7: pin high at power-on
        do_reset(1'b1);
        repeat (6) @(negedge clk);
        check(busy == 1'b0 && done == 1'b0, "R7 no auto run", int'(busy), 0);
        run_cal(1'b0, 2'b01, 2'b01, -1, -1, "R7 software run after tied-high start");
        run_cal(1'b1, 2'b10, 2'b10, -1, -1, "R7 pin run follows selector");

        finish_run();
    end

endmodule